// File: doc/BRIEF.md
# Double-Buffered Serial Master Transceiver

This block is a synchronous serial master. It drives a serial clock and a data output, reads a data input, and moves 8-bit frames in full duplex. Each frame shifts the most significant bit first. Software sees a single data register. A write to it queues a transmit byte. The block moves that byte into a separate shift register as soon as the channel is free, so the next byte can be queued while the current one is on the wire. When a frame ends, the byte received during it is left in the same data register.

A divider derives the serial clock from the system clock. Each half period of the serial clock lasts a programmable number of system cycles. Two status flags are provided:
- a pending-byte flag, which is set while a queued byte waits in the data register;
- a busy flag, which covers a whole run of back-to-back frames.

A mode input selects when the interrupt pulse is raised. In one setting it fires each time the data register empties, which suits streaming. In the other it fires at the end of each frame. The setting is read at the moment of each event, so software may change it while the channel runs. Start and stop pulses enable and disable the channel. A stop aborts a frame that is in flight.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, sclk is 1, busy is 0, buf_full is 0, irq is 0 and rd_data is 0. The channel is disabled until a start pulse.
- R2: A write (wr_en high for one cycle) sets buf_full in the following cycle. A second write while buf_full is 1 replaces the pending byte, and only the last byte written is transmitted.
- R3: While buf_full is 1, rd_data shows the pending transmit byte. This does not alter a frame in progress.
- R4: Frame format: sclk idles at 1, mosi changes on sclk falling edges, and miso is sampled on sclk rising edges. Each frame is 8 bits, most significant bit first, sent and received at the same time.
- R5: Each sclk half period lasts H system cycles, where H = half_per, or 1 when half_per is 0. A single frame keeps busy high for exactly 16*H cycles.
- R6: When a byte moves into the shift register, buf_full clears and busy is set. busy stays high without a gap while frames are chained. A frame whose end finds buf_full set is followed at once by the next frame, with no idle sclk cycles.
- R7: At the end of each frame, the received byte is written to rd_data.
- R8: With int_mode = 1, irq pulses for one cycle each time a byte leaves the data register for the shift register. With int_mode = 0, irq pulses for one cycle at the end of each frame. The mode is taken at the time of the event.
- R9: A stop pulse clears busy and returns sclk to 1 in the next cycle. While the channel is stopped no byte is loaded, and a pending byte is kept. A start pulse re-enables the channel.
- R10: A write in the same cycle as a load sends the previously pending byte and leaves the new byte pending, with buf_full still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that enables the channel |
| stop | input | 1 | One-cycle pulse that disables the channel and aborts a frame |
| int_mode | input | 1 | 1: irq when the data register empties; 0: irq at the end of each frame |
| half_per | input | DIV_W | System cycles per sclk half period (0 is treated as 1) |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Transmit byte to queue |
| rd_data | output | 8 | Data register: the pending transmit byte, or the last received byte |
| buf_full | output | 1 | A transmit byte is waiting in the data register |
| busy | output | 1 | A frame or a run of chained frames is in progress |
| irq | output | 1 | One-cycle interrupt pulse |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The main function is tried with single frames and with four-frame streams at half periods of 1, 2, 3 and 5 cycles. The exact busy length separates divider errors from frames that are short or long by a bit. An arithmetic slave returns a different byte in every frame, which exposes bit-order errors, sampling on the wrong edge, and received bytes landing in the wrong frame. The streaming runs switch the interrupt mode before the last frame, and the busy-cycle count catches any idle gap between chained frames. Directed patterns cover:
- a write colliding with a load;
- a write arriving while a frame is in flight;
- two writes while the channel is stopped;
- a stop in the middle of a frame.

These cases separate correct overwrite, readback and abort behaviour from an off-by-one priority between the write path and the load path.

// File: rtl/spi_dbuf_pkg.sv
// Shared definitions for the double-buffered serial master.
// Assumes a fixed frame length; everything else is parameterised per module.
package spi_dbuf_pkg;
    localparam int FRAME_BITS = 8;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    typedef logic [FRAME_BITS-1:0] frame_t;

    // Interrupt timing selection.
    typedef enum logic {
        IRQ_ON_END   = 1'b0,
        IRQ_ON_EMPTY = 1'b1
    } irq_sel_e;
endpackage

// File: rtl/spi_clk_div.sv
// Half-period timer for the serial clock.
// Produces a one-cycle tick every H system cycles while run is high,
// where H = half_per, with 0 treated as 1. Idles at zero when not running.
module spi_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_per,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    // Effective half period, never below one cycle.
    always_comb begin
        limit = (half_per == '0) ? DIV_W'(1) : half_per;
        tick  = run && (cnt == limit - DIV_W'(1));
    end

    // Count system cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Full-duplex shift engine with an idle-high clock, MSB first.
// A load pulls sclk low at once and presents the MSB. Each tick toggles sclk:
// a rising edge samples miso, a falling edge advances mosi. The frame ends
// at the tick that closes the last high phase. A load in that same cycle
// chains the next frame without an idle period. Abort returns to idle at once.
module spi_shift_engine
    import spi_dbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  frame_t load_data,
    input  logic   abort,
    input  logic   tick,
    input  logic   miso,
    output logic   active,
    output logic   sclk,
    output logic   mosi,
    output logic   frame_done,
    output frame_t rx_byte
);
    logic             sclk_q;
    logic [BIT_W-1:0] bit_cnt;
    frame_t           tx_sr;
    frame_t           rx_sr;

    // Decode the end of the final high phase and drive the pins.
    always_comb begin
        frame_done = active && tick && sclk_q && (bit_cnt == BIT_W'(FRAME_BITS - 1));
        sclk       = sclk_q;
        mosi       = tx_sr[FRAME_BITS-1];
        rx_byte    = rx_sr;
    end

    // Sequence the clock phases and the shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sclk_q  <= 1'b1;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else if (abort) begin
            active  <= 1'b0;
            sclk_q  <= 1'b1;
            bit_cnt <= '0;
        end else if (load) begin
            active  <= 1'b1;
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            tx_sr   <= load_data;
        end else if (frame_done) begin
            active  <= 1'b0;
            sclk_q  <= 1'b1;
        end else if (active && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_sr  <= {rx_sr[FRAME_BITS-2:0], miso};
            end else begin
                sclk_q  <= 1'b0;
                tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                bit_cnt <= bit_cnt + BIT_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_buf_ctrl.sv
// Data register, pending-byte flag, channel enable and interrupt timing.
// Assumes the shift engine reports busy (its active flag) and a one-cycle
// frame_done. A write always wins the data register. A load takes the old
// value, and the received byte is stored only when no write collides with it.
module spi_buf_ctrl
    import spi_dbuf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     stop,
    input  logic     wr_en,
    input  frame_t   wr_data,
    input  irq_sel_e irq_sel,
    input  logic     busy,
    input  logic     frame_done,
    input  frame_t   rx_byte,
    output logic     load,
    output frame_t   data_q,
    output logic     full_q,
    output logic     irq_q
);
    logic enabled;
    logic done_eff;

    // A frame end counts only if no stop arrives in the same cycle.
    always_comb begin
        done_eff = frame_done && !stop;
        load     = enabled && !stop && full_q && (!busy || done_eff);
    end

    // Channel enable: stop has priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enabled <= 1'b0;
        else if (stop)
            enabled <= 1'b0;
        else if (start)
            enabled <= 1'b1;
    end

    // Data register and pending-byte flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (wr_en) begin
            data_q <= wr_data;
            full_q <= 1'b1;
        end else begin
            if (load)
                full_q <= 1'b0;
            if (done_eff)
                data_q <= rx_byte;
        end
    end

    // Interrupt pulse, with the mode read at the time of the event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= (irq_sel == IRQ_ON_EMPTY) ? load : done_eff;
    end
endmodule

// File: rtl/spi_dbuf_master.sv
// Top of the double-buffered serial master.
// Wires the half-period timer, the shift engine and the buffer controller.
// Assumes single-cycle start, stop and wr_en strobes that are synchronous to clk.
module spi_dbuf_master
    import spi_dbuf_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  stop,
    input  logic                  int_mode,
    input  logic [DIV_W-1:0]      half_per,
    input  logic                  wr_en,
    input  logic [FRAME_BITS-1:0] wr_data,
    output logic [FRAME_BITS-1:0] rd_data,
    output logic                  buf_full,
    output logic                  busy,
    output logic                  irq,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso
);
    logic   tick;
    logic   load;
    logic   frame_done;
    frame_t rx_byte;
    frame_t data_q;

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_per (half_per),
        .tick     (tick)
    );

    spi_shift_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_data  (data_q),
        .abort      (stop),
        .tick       (tick),
        .miso       (miso),
        .active     (busy),
        .sclk       (sclk),
        .mosi       (mosi),
        .frame_done (frame_done),
        .rx_byte    (rx_byte)
    );

    spi_buf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .irq_sel    (irq_sel_e'(int_mode)),
        .busy       (busy),
        .frame_done (frame_done),
        .rx_byte    (rx_byte),
        .load       (load),
        .data_q     (data_q),
        .full_q     (full_q_w),
        .irq_q      (irq)
    );

    logic full_q_w;

    // Expose the pending flag and the data register.
    always_comb begin
        buf_full = full_q_w;
        rd_data  = data_q;
    end
endmodule

// File: rtl/spi_dbuf_master_chk.sv
// Protocol checker for spi_dbuf_master, attached by bind.
// Observes only top-level ports.
module spi_dbuf_master_chk (
    input logic clk,
    input logic rst_n,
    input logic stop,
    input logic wr_en,
    input logic buf_full,
    input logic busy,
    input logic irq,
    input logic sclk
);
    // R4: the serial clock rests high whenever no frame is running.
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    // R2: a write leaves a pending byte in the next cycle.
    p_write_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> buf_full);

    // R9: stop aborts at once.
    p_stop_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && sclk));

    // R8: the interrupt is a single-cycle pulse.
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: starting a run consumes the pending byte unless a write refilled it.
    p_load_consumes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!buf_full || $past(wr_en)));
endmodule

bind spi_dbuf_master spi_dbuf_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (stop),
    .wr_en    (wr_en),
    .buf_full (buf_full),
    .busy     (busy),
    .irq      (irq),
    .sclk     (sclk)
);

// File: tb/tb_spi_dbuf_master.sv
module tb_spi_dbuf_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       int_mode = 1'b0;
    logic [7:0] half_per = 8'd1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       buf_full, busy, irq, sclk, mosi;
    logic       miso = 1'b0;

    always #4 clk = ~clk;

    spi_dbuf_master #(.DIV_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .int_mode(int_mode),
        .half_per(half_per), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .buf_full(buf_full), .busy(busy), .irq(irq), .sclk(sclk), .mosi(mosi),
        .miso(miso)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit timed_out = 1'b0;

    function automatic logic [7:0] s_byte(int k);
        return 8'((k * 53 + 7) & 255);
    endfunction

    function automatic logic [7:0] m_byte(int h, int k);
        return 8'((h * 71 + k * 29 + 11) & 255);
    endfunction

    // Slave model: drives miso on falling sclk, captures mosi on rising sclk.
    int         sbit = 0, sframe = 0, cbit = 0, cframe = 0;
    logic [7:0] scur = 8'd0, ccap = 8'd0;
    logic [7:0] m_cap [64];

    always @(negedge sclk) if (rst_n) begin
        if (sbit == 0) scur = s_byte(sframe);
        miso = scur[7 - sbit];
        sbit++;
        if (sbit == 8) begin sbit = 0; sframe++; end
    end

    always @(posedge sclk) if (rst_n) begin
        ccap = {ccap[6:0], mosi};
        cbit++;
        if (cbit == 8) begin cbit = 0; m_cap[cframe % 64] = ccap; cframe++; end
    end

    // Monitor: counts interrupt pulses and busy cycles.
    int irq_cnt = 0, busy_cyc = 0;
    always @(posedge clk) if (rst_n) begin
        if (irq)  irq_cnt++;
        if (busy) busy_cyc++;
    end

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wr2(logic [7:0] a, logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = a;
        @(negedge clk); wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_irq();
        int n = 0;
        @(negedge clk);
        while (!irq && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic run_all();
        int hs [4] = '{1, 2, 3, 5};
        int bc, bi, bb;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "sclk in reset", sclk, 1);
        chk("R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "sclk", sclk, 1);
        chk("R1", "busy", busy, 0);
        chk("R1", "buf_full", buf_full, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "rd_data", rd_data, 0);
        pulse_start();

        foreach (hs[i]) begin
            int h = hs[i];
            half_per = 8'(h);
            // Single frame, end-of-frame interrupt
            int_mode = 1'b0;
            bc = cframe; bi = irq_cnt; bb = busy_cyc;
            wr(m_byte(h, 0));
            chk("R2", "buf_full after write", buf_full, 1);
            wait_idle();
            chk("R4", "slave got byte", m_cap[bc % 64], m_byte(h, 0));
            chk("R4", "frames", cframe - bc, 1);
            chk("R7", "rx byte", rd_data, s_byte(bc));
            chk("R5", "frame cycles", busy_cyc - bb, 16 * h);
            chk("R8", "end irq count", irq_cnt - bi, 1);
            chk("R6", "buf_full cleared", buf_full, 0);
            // Four-frame stream, buffer-empty interrupts, mode switched before the end
            int_mode = 1'b1;
            bc = cframe; bi = irq_cnt; bb = busy_cyc;
            wr(m_byte(h, 1));
            for (int k = 2; k <= 4; k++) begin
                wait_irq();
                wr(m_byte(h, k));
            end
            wait_irq();
            int_mode = 1'b0;
            wait_idle();
            for (int k = 1; k <= 4; k++)
                chk("R4", "stream byte", m_cap[(bc + k - 1) % 64], m_byte(h, k));
            chk("R6", "no idle between frames", busy_cyc - bb, 64 * h);
            chk("R8", "empty irqs plus end irq", irq_cnt - bi, 5);
            chk("R7", "last rx byte", rd_data, s_byte(bc + 3));
        end

        // R10: write colliding with a load
        half_per = 8'd2;
        bc = cframe;
        wr2(8'hA5, 8'h3C);
        chk("R10", "busy", busy, 1);
        chk("R10", "still pending", buf_full, 1);
        chk("R3", "pending readback", rd_data, 8'h3C);
        wait_idle();
        chk("R10", "first out", m_cap[bc % 64], 8'hA5);
        chk("R10", "second out", m_cap[(bc + 1) % 64], 8'h3C);

        // R3: readback while a frame runs
        half_per = 8'd3;
        bc = cframe; bi = irq_cnt; bb = busy_cyc;
        wr(8'h81);
        repeat (6) @(negedge clk);
        wr(8'h6E);
        chk("R3", "readback", rd_data, 8'h6E);
        chk("R3", "buf_full", buf_full, 1);
        chk("R3", "busy kept", busy, 1);
        wait_idle();
        chk("R3", "frame 1 byte", m_cap[bc % 64], 8'h81);
        chk("R3", "frame 2 byte", m_cap[(bc + 1) % 64], 8'h6E);
        chk("R6", "chained cycles", busy_cyc - bb, 96);
        chk("R8", "end irqs", irq_cnt - bi, 2);

        // R2/R9: overwrite while stopped
        half_per = 8'd1;
        pulse_stop();
        wr(8'h11);
        wr(8'hEE);
        repeat (5) @(negedge clk);
        chk("R2", "overwritten", rd_data, 8'hEE);
        chk("R9", "no load when stopped", busy, 0);
        chk("R9", "pending kept", buf_full, 1);
        bc = cframe;
        pulse_start();
        wait_idle();
        chk("R2", "one frame", cframe - bc, 1);
        chk("R2", "last write sent", m_cap[bc % 64], 8'hEE);

        // R9: stop in mid-frame (last, since it leaves the slave out of step)
        half_per = 8'd4;
        wr(8'h5A);
        repeat (20) @(negedge clk);
        pulse_stop();
        chk("R9", "busy after stop", busy, 0);
        chk("R9", "sclk after stop", sclk, 1);
        wr(8'hC3);
        repeat (40) @(negedge clk);
        chk("R9", "idle while stopped", busy, 0);
        chk("R9", "pending while stopped", buf_full, 1);
        chk("R9", "pending value", rd_data, 8'hC3);
        pulse_start();
        repeat (2) @(negedge clk);
        chk("R9", "restart loads", busy, 1);
        wait_idle();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule